// File: doc/BRIEF.md
# Eight-Channel External Request Detector

This block is the front end for eight external request pins on a microcontroller. Each pin is asynchronous to the core clock, so it first passes through a two-stage synchronizer. A per-channel detector then looks for the condition that channel's mode field selects: a low level, a high level, a rising edge or a falling edge. When the condition is seen, the channel's pending flag is set. The flag stays set until software clears it.

Each pending flag is ANDed with that channel's enable bit to form the channel's request toward the CPU's interrupt or data-transfer service logic. An aggregate request line and the index of the lowest-numbered active request are also provided. Software reaches the enable bits, the pending flags and the mode fields through a small byte-wide register port. Reads are combinational and writes take effect on the clock edge.

Top module: `extirq_ctrl`

## Requirements
- R1: Out of reset, the enable byte (offset 0) and both mode bytes (offsets 2 and 3) read 0x00, and no channel request is driven.
- R2: Byte offsets map as follows: 0 is the enable byte (channel n at bit n), 1 is the pending flags (channel n at bit n), 2 holds the mode fields of channels 0 to 3, and 3 holds the mode fields of channels 4 to 7. Channel n's 2-bit mode occupies bits 2n+1 and 2n of the 16-bit value {byte3, byte2}. A write changes only the addressed byte.
- R3: A pin change presented before clock edge E1 sets the pending flag at edge E3, and the flag reads back after E3. This holds for level modes and for edge modes.
- R4: Mode 00 sets the flag on every clock where the synchronized pin is low. Mode 01 does the same when the pin is high.
- R5: Mode 10 sets the flag only on a 0-to-1 transition of the synchronized pin. Mode 11 sets it only on a 1-to-0 transition. Once set, the flag stays set while the pin holds steady.
- R6: A detected condition sets the pending flag even when the channel's enable bit is 0.
- R7: Writing offset 1 clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged. A clear wins over a detection in the same cycle. In a level mode, the flag sets again on the following edge if the level is still present.
- R8: `chan_req_o[n]` is 1 exactly when channel n's pending flag and enable bit are both 1.
- R9: `any_req_o` is the OR of `chan_req_o`. `req_id_o` gives the lowest n with `chan_req_o[n]` set, and reads 0 when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_pin_i | input | 8 | Asynchronous external request pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register byte offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the addressed byte |
| chan_req_o | output | 8 | Gated per-channel requests |
| any_req_o | output | 1 | OR of all gated requests |
| req_id_o | output | 3 | Lowest-numbered active request |

## Verification
Some properties are checked by assertions on every cycle:
- a clear write always wins over a detection in the same cycle;
- a set flag stays set unless it is cleared;
- a level or edge condition seen at the detector's input produces a flag one edge later;
- the reported index is the lowest active request, or zero when nothing is active.

Other behaviour can only be shown by the bench's scenarios, run against a behavioural model:
- the full latency from a pin change to a flag readout through the synchronizer;
- the absence of a flag on the edge direction a mode does not select;
- the rule that a write of 1 leaves a flag unchanged;
- the exact byte placement of each mode field in the register map.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int unsigned N_CH        = 8;
  localparam int unsigned MODE_W      = 2;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned ADDR_W      = 2;
  localparam int unsigned DATA_W      = 8;

  localparam logic [ADDR_W-1:0] OFS_EN      = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_PEND    = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_MODE_LO = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_MODE_HI = 2'd3;

  typedef enum logic [MODE_W-1:0] {
    DET_LOW  = 2'b00,
    DET_HIGH = 2'b01,
    DET_RISE = 2'b10,
    DET_FALL = 2'b11
  } det_mode_e;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/extirq_chan.sv
module extirq_chan
  import extirq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  det_mode_e mode_i,
  input  logic      en_i,
  input  logic      clr_i,
  output logic      pend_o,
  output logic      req_o
);
  logic prev_q, pend_q, det;

  always_comb begin
    unique case (mode_i)
      DET_LOW:  det = !lvl_i;
      DET_HIGH: det = lvl_i;
      DET_RISE: det = lvl_i && !prev_q;
      DET_FALL: det = !lvl_i && prev_q;
      default:  det = 1'b0;
    endcase
  end

  // clear has priority; a persisting level re-sets on the next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= clr_i ? 1'b0 : (pend_q | det);
    end
  end

  assign pend_o = pend_q;
  assign req_o  = pend_q & en_i;

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pend_q);  // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q);  // R5
  AST_HIGH_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == DET_HIGH && lvl_i && !clr_i) |=> pend_q);  // R4
  AST_LOW_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == DET_LOW && !lvl_i && !clr_i) |=> pend_q);  // R4
  AST_RISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == DET_RISE && lvl_i && !prev_q && !clr_i) |=> pend_q);  // R5
  AST_SET_NO_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == DET_FALL && !lvl_i && prev_q && !clr_i && !en_i) |=> pend_q);  // R6
endmodule

// File: rtl/extirq_prio.sv
module extirq_prio #(
  parameter int unsigned N   = 8,
  parameter int unsigned IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   req_i,
  output logic           any_o,
  output logic [IDW-1:0] id_o
);
  always_comb begin
    id_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = IDW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int unsigned N         = N_CH,
  parameter int unsigned STAGES    = SYNC_STAGES,
  localparam int unsigned ID_W     = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned MODE_BITS = MODE_W * N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      req_pin_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N-1:0]      chan_req_o,
  output logic              any_req_o,
  output logic [ID_W-1:0]   req_id_o
);
  logic [N-1:0]         en_q, pend, lvl, clr;
  logic [MODE_BITS-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mode_q <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        OFS_EN:      en_q                  <= reg_wdata_i;
        OFS_MODE_LO: mode_q[DATA_W-1:0]    <= reg_wdata_i;
        OFS_MODE_HI: mode_q[2*DATA_W-1:DATA_W] <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  // write-0-to-clear on the pending byte
  assign clr = (reg_we_i && reg_addr_i == OFS_PEND) ? ~reg_wdata_i : '0;

  always_comb begin
    unique case (reg_addr_i)
      OFS_EN:      reg_rdata_o = en_q;
      OFS_PEND:    reg_rdata_o = pend;
      OFS_MODE_LO: reg_rdata_o = mode_q[DATA_W-1:0];
      default:     reg_rdata_o = mode_q[2*DATA_W-1:DATA_W];
    endcase
  end

  extirq_sync #(.WIDTH(N), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_pin_i),
    .q_o   (lvl)
  );

  for (genvar g = 0; g < N; g++) begin : g_chan
    extirq_chan u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (lvl[g]),
      .mode_i(det_mode_e'(mode_q[MODE_W*g +: MODE_W])),
      .en_i  (en_q[g]),
      .clr_i (clr[g]),
      .pend_o(pend[g]),
      .req_o (chan_req_o[g])
    );
  end

  extirq_prio #(.N(N), .IDW(ID_W)) u_prio (
    .req_i(chan_req_o),
    .any_o(any_req_o),
    .id_o (req_id_o)
  );

  AST_ID_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req_o |-> (chan_req_o[req_id_o] &&
                   ((chan_req_o & ((N'(1) << req_id_o) - N'(1))) == '0)));  // R9
  AST_IDLE_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_req_o |-> (req_id_o == '0 && chan_req_o == '0));  // R9
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == OFS_EN) |=> $stable(en_q));  // R2
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i[1]) |=> $stable(mode_q));  // R2
endmodule

// File: tb/test_extirq_ctrl.sv
`timescale 1ns/1ps
module test_extirq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'hFF;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, creq;
  logic       anyr;
  logic [2:0] rid;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0, pend_known = 1'b0;
  logic [7:0] pv = 8'hFF;

  int m_en, m_mode[8], m_pend[8], m_s1[8], m_s2[8], m_prev[8];

  always #2.5 clk = ~clk;

  extirq_ctrl i_extirq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_pin_i(pins), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .chan_req_o(creq), .any_req_o(anyr), .req_id_o(rid)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // behavioural reference, updated on each edge
  always @(posedge clk or negedge rst_n) begin
    int clrm, det;
    if (!rst_n) begin
      m_en = 0;
      for (int c = 0; c < 8; c++) begin
        m_mode[c] = 0; m_pend[c] = 0; m_s1[c] = 0; m_s2[c] = 0; m_prev[c] = 0;
      end
    end else begin
      clrm = (we && addr == 2'd1) ? (~int'(wdata) & 'hFF) : 0;
      for (int c = 0; c < 8; c++) begin
        case (m_mode[c])
          0: det = (m_s2[c] == 0);
          1: det = (m_s2[c] == 1);
          2: det = (m_s2[c] == 1 && m_prev[c] == 0);
          default: det = (m_s2[c] == 0 && m_prev[c] == 1);
        endcase
        if ((clrm >> c) & 1) m_pend[c] = 0;
        else if (det != 0) m_pend[c] = 1;
        m_prev[c] = m_s2[c];
        m_s2[c] = m_s1[c];
        m_s1[c] = int'(pins[c]);
      end
      if (we) begin
        case (addr)
          2'd0: m_en = int'(wdata);
          2'd2: for (int c = 0; c < 4; c++) m_mode[c] = (int'(wdata) >> (2*c)) & 3;
          2'd3: for (int c = 0; c < 4; c++) m_mode[c+4] = (int'(wdata) >> (2*c)) & 3;
          default: ;
        endcase
      end
    end
  end

  function automatic int m_req();
    int r = 0;
    for (int c = 0; c < 8; c++) if (m_pend[c] != 0 && ((m_en >> c) & 1) != 0) r |= (1 << c);
    return r;
  endfunction

  function automatic int m_rd(logic [1:0] a);
    int r = 0;
    case (a)
      2'd0: r = m_en;
      2'd1: for (int c = 0; c < 8; c++) r |= (m_pend[c] << c);
      2'd2: for (int c = 0; c < 4; c++) r |= (m_mode[c] << (2*c));
      default: for (int c = 0; c < 4; c++) r |= (m_mode[c+4] << (2*c));
    endcase
    return r;
  endfunction

  always @(negedge clk) begin
    int r, id;
    if (rst_n && !done) begin
      r = m_req();
      id = 0;
      for (int c = 7; c >= 0; c--) if ((r >> c) & 1) id = c;
      check("R8 chan_req_o", 32'(creq), 32'(r));
      check("R9 any_req_o", 32'(anyr), 32'(r != 0));
      check("R9 req_id_o", 32'(rid), 32'(id));
      if (addr != 2'd1) check("R2 reg_rdata_o", 32'(rdata), 32'(m_rd(addr)));
      else if (pend_known) check("R3 pending byte", 32'(rdata), 32'(m_rd(addr)));
    end
  end

  task automatic step(logic w, logic [1:0] a, logic [7:0] d);
    pins = pv; we = w; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state
    addr = 2'd0; #1; check("R1 enable reset", 32'(rdata), 32'h0);
    addr = 2'd2; #1; check("R1 mode lo reset", 32'(rdata), 32'h0);
    addr = 2'd3; #1; check("R1 mode hi reset", 32'(rdata), 32'h0);
    check("R1 no request", 32'(creq), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step(0, 2'd1, 8'h00);
    step(1, 2'd1, 8'h00);
    pend_known = 1'b1;
    step(0, 2'd1, 8'h00);
    check("R7 flags cleared", 32'(rdata), 32'h0);
    // R2: modes ch0 low, ch1 high, ch2 rise, ch3 fall
    step(1, 2'd2, 8'hE4);
    step(0, 2'd2, 8'h00); check("R2 mode lo readback", 32'(rdata), 32'hE4);
    step(0, 2'd3, 8'h00); check("R2 mode hi untouched", 32'(rdata), 32'h00);
    step(0, 2'd0, 8'h00); check("R2 enable untouched", 32'(rdata), 32'h00);
    pv[1] = 1'b0;
    repeat (4) step(0, 2'd1, 8'h00);
    step(1, 2'd1, 8'h00);
    step(0, 2'd1, 8'h00); check("R7 cleared before latency test", 32'(rdata), 32'h0);
    // R3: latency through synchronizer
    pv[1] = 1'b1;
    step(0, 2'd1, 8'h00); check("R3 flag after E1", 32'(rdata[1]), 32'h0);
    step(0, 2'd1, 8'h00); check("R3 flag after E2", 32'(rdata[1]), 32'h0);
    step(0, 2'd1, 8'h00); check("R3 flag after E3", 32'(rdata[1]), 32'h1);
    // R4: low level
    pv[0] = 1'b0;
    repeat (3) step(0, 2'd1, 8'h00);
    check("R4 low level flag", 32'(rdata[0]), 32'h1);
    // R5: rising/falling
    pv[2] = 1'b0;
    repeat (3) step(0, 2'd1, 8'h00);
    check("R5 no flag on fall in rise mode", 32'(rdata[2]), 32'h0);
    pv[2] = 1'b1;
    repeat (3) step(0, 2'd1, 8'h00);
    check("R5 rise flag", 32'(rdata[2]), 32'h1);
    pv[3] = 1'b0;
    repeat (3) step(0, 2'd1, 8'h00);
    check("R5 fall flag", 32'(rdata[3]), 32'h1);
    pv[3] = 1'b1;
    repeat (3) step(0, 2'd1, 8'h00);
    check("R5 flag held after pin returns", 32'(rdata[3]), 32'h1);
    // R7: selective clear, then level re-set
    step(1, 2'd1, 8'hF7);
    check("R7 write0 clears, write1 keeps", 32'(rdata & 8'h0C), 32'h04);
    step(1, 2'd1, 8'hFE);
    check("R7 clear wins", 32'(rdata[0]), 32'h0);
    step(0, 2'd1, 8'h00);
    check("R7 level re-sets", 32'(rdata[0]), 32'h1);
    // R6: flags set while disabled
    check("R6 flag with enable 0", 32'(rdata & 8'h07), 32'h07);
    check("R6 no request while disabled", 32'(creq), 32'h0);
    // R8 / R9
    step(1, 2'd0, 8'h05);
    check("R8 gated requests", 32'(creq), 32'h05);
    check("R9 lowest id", 32'(rid), 32'h0);
    step(1, 2'd0, 8'h0C);
    check("R8 gated requests", 32'(creq), 32'h04);
    check("R9 lowest id", 32'(rid), 32'h2);
    check("R9 any", 32'(anyr), 32'h1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      pv = 8'($urandom);
      if ($urandom % 8 == 0) step(1, 2'($urandom), 8'($urandom));
      else step(0, 2'($urandom), 8'h00);
    end
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule